// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block holds four alarm bytes (minute, hour, day of month, weekday mask) and a control byte, and compares the alarm against the current time of a real-time clock once per minute. The clock supplies its minute, hour and day of month as packed BCD bytes, its weekday as an index, and a one-cycle pulse on each minute boundary. When every field taking part in the compare agrees at a minute pulse, a sticky alarm flag is set. The flag stays set until software writes the control byte with the flag bit at 0.

Each BCD alarm byte has an ignore bit in bit 7 that makes its field match any time, so hourly and daily alarms need no reprogramming. The weekday byte is a day mask, so an alarm can be armed on any set of days. The interrupt pin is active low and open-drain style. It is modelled as a level plus an output enable, and it is driven only when the alarm interrupt is the sole enabled interrupt source.

Top module: `cal_alarm_unit`

## Requirements
- R1: After reset the four alarm bytes (addresses 0 to 3) read 0x80, the control byte (address 4) reads 0x00, irq_oe_o is 0 and irq_n_o is 1.
- R2: A write to addresses 0 to 3 stores all 8 bits, and reads return them. A write to address 4 stores bits 2:0 (bit 0 alarm interrupt enable, bit 1 timer interrupt enable, bit 2 frequency-output enable). A read of address 4 returns the flag in bit 3 and 0 in bits 7:4. Addresses 5 to 7 read 0.
- R3: The minute (address 0), hour (address 1) and day (address 2) alarm bytes with bit 7 at 0 match only when the time byte equals {1'b0, alarm[6:0]}. A mismatch in any compared field prevents the flag from setting.
- R4: An alarm byte with bit 7 at 1 matches for every time value of its field, including the weekday field.
- R5: Weekday mask (address 3) bit n selects weekday index n, with 0 for Sunday through 6 for Saturday. Several bits may be set. A weekday index of 7 never matches unless the weekday byte's bit 7 is 1.
- R6: If the minute and hour alarm bytes both have bit 7 at 1, the flag never sets.
- R7: The flag sets on the clock edge where tick_min_i is 1 and all fields match, and only then. It then holds until a write to address 4 with bit 3 at 0. When a set and a clear arrive in the same cycle, the set wins.
- R8: The interrupt is active exactly when the flag is 1, the alarm interrupt enable is 1, and the timer interrupt enable and frequency-output enable are both 0. While active, irq_oe_o is 1 and irq_n_o is 0. Otherwise irq_oe_o is 0 and irq_n_o is 1.
- R9: The flag sets and reads back when the alarm interrupt enable is 0, without driving the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| tick_min_i | input | 1 | One-cycle pulse on each minute boundary |
| min_i | input | 8 | Current minute, packed BCD |
| hour_i | input | 8 | Current hour, packed BCD |
| wday_i | input | 3 | Current weekday index, 0 Sunday to 6 Saturday |
| day_i | input | 8 | Current day of month, packed BCD |
| irq_n_o | output | 1 | Interrupt level, low when active |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The assertions check on every cycle that the pin level and output enable agree with each other and with the enable gating. They also check that the flag never sets without a minute pulse, that it holds until a clearing write, and that an alarm with both hour and minute ignored never sets it. The compare function itself can only be shown by the bench scenarios. These cover the full weekday mask against every weekday index, a raw sweep of the minute and hour bytes, every combination of ignore bits against matching and mismatching fields, the enable gating combinations, and a set and a clear landing in the same cycle.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 3;
  localparam int unsigned NDAYS = 7;
  localparam int unsigned NBCD = 3;  // minute, hour, day

  typedef enum logic [AW-1:0] {
    A_MIN  = 3'd0,
    A_HOUR = 3'd1,
    A_DAY  = 3'd2,
    A_WDAY = 3'd3,
    A_CTRL = 3'd4
  } reg_addr_e;

  localparam int unsigned CTL_AIE  = 0;
  localparam int unsigned CTL_TIE  = 1;
  localparam int unsigned CTL_FOE  = 2;
  localparam int unsigned CTL_FLAG = 3;
  localparam int unsigned CTLW     = 3;
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
#(
  parameter int unsigned W = DW,
  parameter int unsigned A = AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [A-1:0]  wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [A-1:0]  rd_addr_i,
  input  logic          flag_i,
  output logic [W-1:0]  rd_data_o,
  output logic [W-1:0]  al_min_o,
  output logic [W-1:0]  al_hour_o,
  output logic [W-1:0]  al_day_o,
  output logic [W-1:0]  al_wday_o,
  output logic [CTLW-1:0] ctrl_o,
  output logic          clr_o
);
  localparam logic [W-1:0] IGN_RST = W'(1) << (W - 1);
  localparam int unsigned PADW = W - CTLW - 1;

  logic [W-1:0] min_q, hour_q, day_q, wday_q;
  logic [CTLW-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_q  <= IGN_RST;
      hour_q <= IGN_RST;
      day_q  <= IGN_RST;
      wday_q <= IGN_RST;
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_MIN:  min_q  <= wr_data_i;
        A_HOUR: hour_q <= wr_data_i;
        A_DAY:  day_q  <= wr_data_i;
        A_WDAY: wday_q <= wr_data_i;
        A_CTRL: ctrl_q <= wr_data_i[CTLW-1:0];
        default: ;
      endcase
    end
  end

  assign clr_o = wr_en_i && (wr_addr_i == A_CTRL) && !wr_data_i[CTL_FLAG];

  always_comb begin
    case (rd_addr_i)
      A_MIN:   rd_data_o = min_q;
      A_HOUR:  rd_data_o = hour_q;
      A_DAY:   rd_data_o = day_q;
      A_WDAY:  rd_data_o = wday_q;
      A_CTRL:  rd_data_o = {{PADW{1'b0}}, flag_i, ctrl_q};
      default: rd_data_o = '0;
    endcase
  end

  assign al_min_o  = min_q;
  assign al_hour_o = hour_q;
  assign al_day_o  = day_q;
  assign al_wday_o = wday_q;
  assign ctrl_o    = ctrl_q;
endmodule

// File: rtl/cal_field_cmp.sv
module cal_field_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] alarm_i,
  input  logic [W-1:0] time_i,
  output logic         hit_o
);
  // bit W-1 of the alarm byte means "ignore"
  assign hit_o = alarm_i[W-1] || ({1'b0, alarm_i[W-2:0]} == time_i);
endmodule

// File: rtl/cal_wday_cmp.sv
module cal_wday_cmp #(
  parameter int unsigned W     = 8,
  parameter int unsigned NDAYS = 7,
  localparam int unsigned IW   = $clog2(NDAYS + 1),
  localparam int unsigned NPAD = 1 << IW
) (
  input  logic [W-1:0]  mask_i,
  input  logic [IW-1:0] idx_i,
  output logic          hit_o
);
  logic [NPAD-1:0] sel;
  always_comb begin
    sel = '0;
    sel[NDAYS-1:0] = mask_i[NDAYS-1:0];
  end
  assign hit_o = mask_i[W-1] || sel[idx_i];
endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hit_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              flag_o <= 1'b0;
    else if (tick_i && hit_i) flag_o <= 1'b1;  // set beats clear
    else if (clr_i)           flag_o <= 1'b0;
  end
endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
  import cal_alarm_pkg::*;
#(
  parameter int unsigned W  = DW,
  parameter int unsigned A  = AW,
  parameter int unsigned ND = NDAYS,
  localparam int unsigned IW = $clog2(ND + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [A-1:0]  wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [A-1:0]  rd_addr_i,
  output logic [W-1:0]  rd_data_o,
  input  logic          tick_min_i,
  input  logic [W-1:0]  min_i,
  input  logic [W-1:0]  hour_i,
  input  logic [IW-1:0] wday_i,
  input  logic [W-1:0]  day_i,
  output logic          irq_n_o,
  output logic          irq_oe_o
);
  logic [W-1:0] al_min, al_hour, al_day, al_wday;
  logic [CTLW-1:0] ctrl;
  logic clr, flag, wday_hit, all_hit, unsupported;
  logic [W-1:0] al_arr [NBCD];
  logic [W-1:0] tm_arr [NBCD];
  logic [NBCD-1:0] bcd_hit;

  cal_alarm_regs #(.W(W), .A(A)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i,
    .flag_i(flag), .rd_data_o,
    .al_min_o(al_min), .al_hour_o(al_hour), .al_day_o(al_day),
    .al_wday_o(al_wday), .ctrl_o(ctrl), .clr_o(clr)
  );

  assign al_arr[0] = al_min;  assign tm_arr[0] = min_i;
  assign al_arr[1] = al_hour; assign tm_arr[1] = hour_i;
  assign al_arr[2] = al_day;  assign tm_arr[2] = day_i;

  for (genvar g = 0; g < NBCD; g++) begin : g_bcd
    cal_field_cmp #(.W(W)) u_cmp (
      .alarm_i(al_arr[g]), .time_i(tm_arr[g]), .hit_o(bcd_hit[g])
    );
  end

  cal_wday_cmp #(.W(W), .NDAYS(ND)) u_wday (
    .mask_i(al_wday), .idx_i(wday_i), .hit_o(wday_hit)
  );

  // a compare with neither minute nor hour taking part is not armed
  assign unsupported = al_min[W-1] && al_hour[W-1];
  assign all_hit     = (&bcd_hit) && wday_hit && !unsupported;

  cal_alarm_flag u_flag (
    .clk_i, .rst_ni, .tick_i(tick_min_i), .hit_i(all_hit), .clr_i(clr),
    .flag_o(flag)
  );

  logic irq_act;
  assign irq_act  = flag && ctrl[CTL_AIE] && !ctrl[CTL_TIE] && !ctrl[CTL_FOE];
  assign irq_oe_o = irq_act;
  assign irq_n_o  = !irq_act;
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk
  import cal_alarm_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tick_min_i,
  input logic            flag,
  input logic            clr,
  input logic [CTLW-1:0] ctrl,
  input logic [W-1:0]    al_min,
  input logic [W-1:0]    al_hour,
  input logic            irq_n_o,
  input logic            irq_oe_o
);
  a_r8_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_oe_o |-> (flag && ctrl[CTL_AIE] && !ctrl[CTL_TIE] && !ctrl[CTL_FOE]));
  a_r8_pin_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_oe_o != irq_n_o);
  a_r9_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl[CTL_AIE] |-> irq_n_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && !clr) |=> flag);
  a_r7_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag && !tick_min_i) |=> !flag);
  a_r6_unsupported: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag && al_min[W-1] && al_hour[W-1]) |=> !flag);
endmodule

bind cal_alarm_unit cal_alarm_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_min_i(tick_min_i), .flag(flag),
  .clr(clr), .ctrl(ctrl), .al_min(al_min), .al_hour(al_hour),
  .irq_n_o(irq_n_o), .irq_oe_o(irq_oe_o)
);

// File: tb/cal_alarm_unit_tb.sv
`timescale 1ns/1ps
module cal_alarm_unit_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, tick = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0, wday = 0;
  logic [7:0] wr_data = 0, rd_data, tmin = 0, thour = 0, tday = 0;
  logic irq_n, irq_oe;
  int errors = 0, checks = 0;
  logic [2:0] cur_ctrl = 0;

  always #4 clk = ~clk;

  cal_alarm_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .tick_min_i(tick), .min_i(tmin), .hour_i(thour), .wday_i(wday),
    .day_i(tday), .irq_n_o(irq_n), .irq_oe_o(irq_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    if (a == 3'd4) cur_ctrl = d[2:0];
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic pins(input string req, input logic act);
    chk(req, {irq_oe, irq_n}, act ? 2'b10 : 2'b01);
  endtask

  // clear the flag, apply time with a minute pulse, check flag and pins
  task automatic tick_chk(input string req, input logic [7:0] m, h, d,
                          input logic [2:0] wd, input logic exp);
    logic [7:0] r;
    wr(3'd4, {5'b0, cur_ctrl});
    tmin = m; thour = h; tday = d; wday = wd; tick = 1;
    @(posedge clk); @(negedge clk);
    tick = 0;
    rd(3'd4, r);
    chk(req, r[3], exp);
    pins(req, exp && cur_ctrl == 3'b001);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic e;
    repeat (2) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(3'(a), r); chk("R1 alarm reset", r, 8'h80); end
    rd(3'd4, r); chk("R1 ctrl reset", r, 8'h00);
    pins("R1 pins reset", 0);
    rst_n = 1;
    @(negedge clk);
    // R2 register access
    for (int a = 0; a < 4; a++) begin
      wr(3'(a), 8'h5A ^ 8'(a)); rd(3'(a), r); chk("R2 rw", r, 8'h5A ^ 8'(a));
      wr(3'(a), 8'hA5); rd(3'(a), r); chk("R2 rw", r, 8'hA5);
    end
    wr(3'd4, 8'hFF); rd(3'd4, r); chk("R2 ctrl mask", r, 8'h07);
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 8'hFF); rd(3'(a), r); chk("R2 unmapped", r, 8'h00);
    end
    wr(3'd4, 8'h01);
    // R5 weekday mask against every index
    wr(3'd0, 8'h15); wr(3'd1, 8'h80); wr(3'd2, 8'h80);
    for (int m = 0; m < 128; m++) begin
      wr(3'd3, 8'(m));
      for (int i = 0; i < 8; i++)
        tick_chk("R5 wday mask", 8'h15, 8'h00, 8'h00, 3'(i), i < 7 && m[i]);
    end
    wr(3'd3, 8'h80);
    tick_chk("R4 wday ignore idx7", 8'h15, 8'h00, 8'h00, 3'd7, 1);
    // R3 minute and hour raw sweeps
    wr(3'd0, 8'h42); wr(3'd1, 8'h07);
    for (int t = 0; t < 256; t++)
      tick_chk("R3 min sweep", 8'(t), 8'h07, 8'h00, 3'd2, t == 8'h42);
    for (int t = 0; t < 256; t++)
      tick_chk("R3 hour sweep", 8'h42, 8'(t), 8'h00, 3'd2, t == 8'h07);
    // R3 R4 R6 ignore combinations vs per-field mismatch
    for (int ig = 0; ig < 16; ig++)
      for (int mis = 0; mis < 16; mis++) begin
        wr(3'd0, {ig[0], 7'h33}); wr(3'd1, {ig[1], 7'h12});
        wr(3'd2, {ig[2], 7'h28}); wr(3'd3, {ig[3], 7'h10});
        e = (ig[0] || !mis[0]) && (ig[1] || !mis[1]) && (ig[2] || !mis[2]) &&
            (ig[3] || !mis[3]) && !(ig[0] && ig[1]);
        tick_chk(ig[0] && ig[1] ? "R6 min+hour ignored" : "R4 ignore combo",
                 mis[0] ? 8'h34 : 8'h33, mis[1] ? 8'h13 : 8'h12,
                 mis[2] ? 8'h29 : 8'h28, mis[3] ? 3'd3 : 3'd4, e);
      end
    // R8 gating over enable combinations, flag kept with bit3=1 writes
    wr(3'd0, 8'h05); wr(3'd1, 8'h80); wr(3'd2, 8'h80); wr(3'd3, 8'h80);
    tick_chk("R7 set", 8'h05, 8'h00, 8'h00, 3'd0, 1);
    for (int c = 0; c < 8; c++) begin
      wr(3'd4, {5'b00001, 3'(c)});
      rd(3'd4, r); chk("R8 flag kept", r[3], 1);
      pins("R8 gating", c == 1);
    end
    // R9 flag with alarm interrupt disabled
    wr(3'd4, 8'h00);
    tick_chk("R9 flag without enable", 8'h05, 8'h00, 8'h00, 3'd0, 1);
    wr(3'd4, 8'h01);
    // R7 hold across non-matching ticks, no set without tick
    tick_chk("R7 set", 8'h05, 8'h00, 8'h00, 3'd0, 1);
    wr(3'd4, 8'h09);
    for (int k = 0; k < 4; k++) begin
      tmin = 8'h06; tick = 1; @(posedge clk); @(negedge clk); tick = 0;
      rd(3'd4, r); chk("R7 hold", r[3], 1); pins("R7 hold pins", 1);
    end
    wr(3'd4, 8'h01); rd(3'd4, r); chk("R7 clear", r[3], 0); pins("R7 clear pins", 0);
    tmin = 8'h05; repeat (3) @(negedge clk);
    rd(3'd4, r); chk("R7 no tick no set", r[3], 0);
    // R7 set wins over same-cycle clear
    wr_en = 1; wr_addr = 3'd4; wr_data = 8'h01; tick = 1;
    @(posedge clk); @(negedge clk); wr_en = 0; tick = 0;
    rd(3'd4, r); chk("R7 set beats clear", r[3], 1); pins("R7 set beats clear pins", 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule